// File: doc/BRIEF.md
# Deep Sleep Wake-Source Latch

This block keeps a 16-bit word of sticky flags that tell software, once the controller has come back from its deepest low-power state, which event brought it out. Six hardware event inputs feed it: an interrupt-on-change detector, a fault detector, the sleep watchdog timeout, a real-time clock alarm, an assertion of the external reset pin, and the supply power-on detector. Each event sets its own flag, and the flag stays set until something clears it.

The first five flags capture only while the deep-sleep-active level is high. The supply power-on flag captures at any time. Software arms a new deep sleep through a strobe that marks a write of one to the deep-sleep-enable control bit. That strobe wipes every flag, so each sleep period starts with a clean record. A reset indication comes with a tag that says whether it was caused by a deep sleep exit. When the tag is low and the device is awake, the reset clears all flags. In every other case the reset leaves the flags as they are, so the wake reason survives the exit. The read port always shows the packed word. On the write port, a zero in an implemented bit clears that flag, and a one does nothing.

Top module: `dsleep_wake_latch`

## Requirements
- R1: `rd_data_o` packs the flags at fixed positions: bit 8 interrupt-on-change, bit 7 fault, bit 4 watchdog timeout, bit 3 clock alarm, bit 2 reset-pin assertion, bit 0 supply power-on. Bits 15..9, 6, 5 and 1 always read 0. After `rst_n` every bit reads 0.
- R2: A flag that is set stays set until one of three things clears it: an arm strobe, a reset taken outside deep sleep, or a software write of zero to that bit.
- R3: A pulse on `ev_ioc_i`, `ev_fault_i`, `ev_wdt_i`, `ev_rtc_i` or `ev_pin_rst_i` sets its flag one cycle later only if `ds_active_i` is 1 in the cycle of the pulse. With `ds_active_i` at 0 the pulse has no effect. `ev_pin_rst_i` marks an actual assertion of the pin.
- R4: A pulse on `ds_arm_i` clears all flags one cycle later. It also wins over any event flag pulsed in the same cycle.
- R5: A pulse on `rst_evt_i` with `rst_from_ds_i` at 0 and `ds_active_i` at 0 clears all flags one cycle later.
- R6: A pulse on `rst_evt_i` clears nothing in two cases: when `rst_from_ds_i` is 1, or when `ds_active_i` is 1. The power-on flag in particular is kept.
- R7: A pulse on `ev_supply_por_i` sets bit 0 one cycle later, whatever the state of `ds_active_i`. This set also wins over an arm strobe or a reset clear in the same cycle.
- R8: A write (`wr_en_i` = 1) with a 0 in an implemented bit position of `wr_data_i` clears that flag one cycle later.
- R9: If a hardware set and a software write of zero hit the same flag in the same cycle, the flag ends up set.
- R10: A write of 1 to an implemented bit never sets it. Any value written to an unimplemented bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all flags |
| ds_active_i | input | 1 | High while deep sleep is active |
| ds_arm_i | input | 1 | Single-cycle strobe: software wrote 1 to the deep-sleep-enable bit |
| rst_evt_i | input | 1 | Single-cycle power-on reset indication |
| rst_from_ds_i | input | 1 | Tag for `rst_evt_i`: the reset came from a deep sleep exit |
| ev_ioc_i | input | 1 | Interrupt-on-change event pulse |
| ev_fault_i | input | 1 | Fault detect event pulse |
| ev_wdt_i | input | 1 | Sleep watchdog timeout pulse |
| ev_rtc_i | input | 1 | Real-time clock alarm pulse |
| ev_pin_rst_i | input | 1 | External reset pin asserted pulse |
| ev_supply_por_i | input | 1 | Supply power-on detector pulse |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Write data; 0 in an implemented bit clears it |
| rd_data_o | output | 16 | Packed flag word |

## Verification
The bench builds the block with its default 16-bit word and six sources. At that size every combination of the six event inputs can be swept, 64 patterns, once with deep sleep active and once with it inactive. Expected words come from the fixed bit positions. Single-bit clear writes and the all-ones write are swept over every bit, and simultaneous set/clear, arm and reset cases are run against a fully set word.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    localparam int WORD_W  = 16;
    localparam int NUM_SRC = 6;
    localparam int POR_IDX = 5;

    // source index -> bit position in the read word
    function automatic int src_pos(input int s);
        case (s)
            0:       return 8;  // interrupt-on-change
            1:       return 7;  // fault
            2:       return 4;  // watchdog timeout
            3:       return 3;  // clock alarm
            4:       return 2;  // reset pin asserted
            default: return 0;  // supply power-on
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] impl_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) m[src_pos(s)] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] IMPL_MASK = impl_mask();

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } wake_state_t;
endpackage

// File: rtl/dsw_event_gate.sv
module dsw_event_gate #(
    parameter int NUM_SRC = 6,
    parameter int POR_IDX = 5
) (
    input  logic               ds_active_i,
    input  logic [NUM_SRC-1:0] ev_i,
    output logic [NUM_SRC-1:0] set_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        if (s == POR_IDX) begin : g_free
            assign set_o[s] = ev_i[s];
        end else begin : g_sleep
            assign set_o[s] = ev_i[s] & ds_active_i;
        end
    end
endmodule

// File: rtl/dsw_flag_next.sv
module dsw_flag_next #(
    parameter bit SET_OVER_HARD = 1'b0
) (
    input  logic flag_q,
    input  logic set_i,
    input  logic hard_clr_i,
    input  logic soft_clr_i,
    output logic flag_d
);
    always_comb begin
        flag_d = flag_q;
        if (SET_OVER_HARD) begin
            if (set_i)                        flag_d = 1'b1;
            else if (hard_clr_i || soft_clr_i) flag_d = 1'b0;
        end else begin
            if (hard_clr_i)      flag_d = 1'b0;
            else if (set_i)      flag_d = 1'b1;
            else if (soft_clr_i) flag_d = 1'b0;
        end
    end
endmodule

// File: rtl/dsw_word_pack.sv
module dsw_word_pack
    import dsw_pkg::*;
(
    input  logic [NUM_SRC-1:0] flags_i,
    output logic [WORD_W-1:0]  word_o
);
    always_comb begin
        word_o = '0;
        for (int s = 0; s < NUM_SRC; s++) word_o[src_pos(s)] = flags_i[s];
    end
endmodule

// File: rtl/dsleep_wake_latch.sv
module dsleep_wake_latch
    import dsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ds_active_i,
    input  logic              ds_arm_i,
    input  logic              rst_evt_i,
    input  logic              rst_from_ds_i,
    input  logic              ev_ioc_i,
    input  logic              ev_fault_i,
    input  logic              ev_wdt_i,
    input  logic              ev_rtc_i,
    input  logic              ev_pin_rst_i,
    input  logic              ev_supply_por_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o
);
    wake_state_t        state_d, state_q;
    logic [NUM_SRC-1:0] ev_raw, set_vec, soft_clr, flag_next;
    logic               hard_clr;

    assign ev_raw = {ev_supply_por_i, ev_pin_rst_i, ev_rtc_i,
                     ev_wdt_i, ev_fault_i, ev_ioc_i};

    assign hard_clr = ds_arm_i | (rst_evt_i & ~rst_from_ds_i & ~ds_active_i);

    dsw_event_gate #(
        .NUM_SRC (NUM_SRC),
        .POR_IDX (POR_IDX)
    ) gate_i (
        .ds_active_i (ds_active_i),
        .ev_i        (ev_raw),
        .set_o       (set_vec)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        assign soft_clr[s] = wr_en_i & ~wr_data_i[src_pos(s)];
        dsw_flag_next #(
            .SET_OVER_HARD (s == POR_IDX)
        ) next_i (
            .flag_q     (state_q.flags[s]),
            .set_i      (set_vec[s]),
            .hard_clr_i (hard_clr),
            .soft_clr_i (soft_clr[s]),
            .flag_d     (flag_next[s])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    dsw_word_pack pack_i (
        .flags_i (state_q.flags),
        .word_o  (rd_data_o)
    );
endmodule

// File: rtl/dsw_wake_checker.sv
module dsw_wake_checker
    import dsw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ds_active_i,
    input logic              ds_arm_i,
    input logic              rst_evt_i,
    input logic              rst_from_ds_i,
    input logic              ev_ioc_i,
    input logic              ev_supply_por_i,
    input logic              wr_en_i,
    input logic [WORD_W-1:0] wr_data_i,
    input logic [WORD_W-1:0] rd_data_o
);
    logic any_clear;
    assign any_clear = ds_arm_i | wr_en_i | (rst_evt_i & ~rst_from_ds_i & ~ds_active_i);

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~IMPL_MASK) == '0); // R1

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clear |=> (($past(rd_data_o) & ~rd_data_o) == '0)); // R2

    AST_NO_SET_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_active_i |=> ((rd_data_o & ~$past(rd_data_o) & IMPL_MASK & ~WORD_W'(1)) == '0)); // R3

    AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_arm_i && !ev_supply_por_i) |=> (rd_data_o == '0)); // R4

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && !rst_from_ds_i && !ds_active_i && !ev_supply_por_i) |=> (rd_data_o == '0)); // R5

    AST_RST_DS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && (rst_from_ds_i || ds_active_i) && !ds_arm_i && !wr_en_i)
        |=> (($past(rd_data_o) & ~rd_data_o) == '0)); // R6

    AST_SUPPLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_supply_por_i |=> rd_data_o[0]); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_active_i && ev_ioc_i && !ds_arm_i && wr_en_i && !wr_data_i[8]) |=> rd_data_o[8]); // R9

    AST_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !ev_supply_por_i && !ds_active_i)
        |=> ((rd_data_o & ~$past(rd_data_o)) == '0)); // R10
endmodule

bind dsleep_wake_latch dsw_wake_checker chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .ds_active_i     (ds_active_i),
    .ds_arm_i        (ds_arm_i),
    .rst_evt_i       (rst_evt_i),
    .rst_from_ds_i   (rst_from_ds_i),
    .ev_ioc_i        (ev_ioc_i),
    .ev_supply_por_i (ev_supply_por_i),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .rd_data_o       (rd_data_o)
);

// File: tb/dsleep_wake_latch_tb_top.sv
module dsleep_wake_latch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ds_active, ds_arm, rst_evt, rst_from_ds, wr_en;
    logic [5:0]  ev;
    logic [15:0] wr_data, rd_data;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dsleep_wake_latch dut_i (
        .clk (clk), .rst_n (rst_n),
        .ds_active_i (ds_active), .ds_arm_i (ds_arm),
        .rst_evt_i (rst_evt), .rst_from_ds_i (rst_from_ds),
        .ev_ioc_i (ev[0]), .ev_fault_i (ev[1]), .ev_wdt_i (ev[2]),
        .ev_rtc_i (ev[3]), .ev_pin_rst_i (ev[4]), .ev_supply_por_i (ev[5]),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data)
    );

    // source index -> word bit: 0->8 1->7 2->4 3->3 4->2 5->0
    function automatic logic [15:0] expand(input logic [5:0] v);
        return {7'd0, v[0], v[1], 2'd0, v[2], v[3], v[4], 1'b0, v[5]};
    endfunction

    localparam logic [15:0] FULL = 16'h019D;

    task automatic idle();
        ds_arm = 0; rst_evt = 0; rst_from_ds = 0; ev = '0; wr_en = 0; wr_data = '0;
    endtask

    // inputs applied here at a falling edge, captured at the next rising edge,
    // result sampled at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic wipe();
        ds_active = 0; rst_evt = 1; step();
    endtask

    task automatic fill();
        ds_active = 1; ev = 6'h3F; step();
    endtask

    initial begin
        ds_active = 0; idle();
        repeat (3) @(negedge clk);
        check("R1 reset", 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R7 / R1: sweep every event combination awake and asleep
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 64; v++) begin
                wipe();
                ds_active = a[0]; ev = v[5:0]; step();
                check(a ? "R3 asleep set" : "R3 R7 awake", a ? expand(v[5:0]) : expand(v[5:0] & 6'h20));
            end
        end

        // R2: held flags survive idle cycles and a toggle of ds_active
        fill();
        ds_active = 0; step(); step();
        check("R2 sticky", FULL);

        // R8: clear each implemented bit singly
        for (int b = 0; b < 16; b++) begin
            fill();
            wr_en = 1; wr_data = ~(16'h1 << b); step();
            check("R8 clear bit", FULL & ~(16'h1 << b));
        end

        // R10: writes of all ones do nothing, also from empty
        fill();
        wr_en = 1; wr_data = 16'hFFFF; step();
        check("R10 ones keep", FULL);
        wipe();
        wr_en = 1; wr_data = 16'hFFFF; step();
        check("R10 ones no set", 16'h0000);

        // R9: hardware set beats software clear
        wipe();
        ds_active = 1; ev = 6'h01; wr_en = 1; wr_data = 16'h0000; step();
        check("R9 ioc set wins", 16'h0100);
        fill();
        ev = 6'h20; wr_en = 1; wr_data = 16'h0000; step();
        check("R9 por set wins", 16'h0001);

        // R4: arm clears, beats events, not supply por
        fill();
        ds_active = 0; ds_arm = 1; step();
        check("R4 arm clear", 16'h0000);
        ds_active = 1; ds_arm = 1; ev = 6'h1F; step();
        check("R4 arm beats event", 16'h0000);
        fill();
        ds_arm = 1; ev = 6'h20; step();
        check("R4 R7 arm with por", 16'h0001);

        // R5: reset outside deep sleep clears
        fill();
        ds_active = 0; rst_evt = 1; step();
        check("R5 reset clear", 16'h0000);
        fill();
        ds_active = 0; rst_evt = 1; ev = 6'h20; step();
        check("R5 R7 reset with por", 16'h0001);

        // R6: reset from deep sleep exit or during deep sleep keeps flags
        fill();
        ds_active = 0; rst_evt = 1; rst_from_ds = 1; step();
        check("R6 exit reset keep", FULL);
        fill();
        ds_active = 1; rst_evt = 1; step();
        check("R6 asleep reset keep", FULL);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule